// File: doc/BRIEF.md
# Compressed Trace Stream Unpacker

This block rebuilds a sampled signal trace from the compressed word stream that a logic-analyzer capture unit produces on readout. Each 32-bit word either moves a write pointer (an address word) or stores a 31-bit sample at that pointer and advances it (a data word). The block owns a sample memory of `DEPTH` locations, which must be power of two. Before it takes any stream word it clears every location to zero, so samples that the stream skips over read back as zero.

The controller is a two-state machine. `ST_SWEEP` writes zero to one location per cycle, holds `busy_o` high and `in_ready_o` low. `ST_DECODE` accepts one word per clock through a valid/ready handshake. Three transitions exist. Reset enters `ST_SWEEP`. `ST_SWEEP` moves to `ST_DECODE` after it writes the last location. `ST_DECODE` moves to `ST_SWEEP` on a clear pulse. A separate synchronous read port returns the contents of any location one cycle after its address is presented. A saturating counter reports how many data words have been stored since the last clear.

Top module: `trace_unpacker`

## Requirements
- R1: Reset places the block in the sweep state. Counting from the first cycle after reset is released, `busy_o` stays high for exactly `DEPTH` cycles. After that, every location reads as zero.
- R2: A `clr_i` pulse in the decode state raises `busy_o` on the next cycle and holds it for `DEPTH` cycles. After that, every location reads as zero.
- R3: `in_ready_o` is the inverse of `busy_o`. While the block is not busy it accepts one word on every clock where `in_valid_i` is high, with no gaps. Words offered while busy are not taken.
- R4: A word with bit 31 set is an address word. The low log2(`DEPTH`) bits of the word load the write pointer. Nothing is written to memory, and the word does not count as a data word.
- R5: A word with bit 31 clear is a data word. Bits 30:0 are written at the write pointer, and the pointer then increments modulo `DEPTH`, so it wraps from `DEPTH-1` to 0.
- R6: Every clear resets the write pointer to 0. Data words that arrive before the first address word are stored at locations 0, 1, 2 and onward.
- R7: When address words arrive back to back, each one overwrites the pointer, so only the last one decides where the next data word lands.
- R8: `rd_data_o` shows the location addressed by `rd_addr_i` one cycle later. If the same location is written in the same cycle, the read returns the old value.
- R9: `wr_count_o` counts data words stored since the last clear or reset. It starts at 0 and saturates at 2^`CNT_W`-1.
- R10: If a clear pulse and an accepted word fall in the same cycle, the clear wins: the pointer and counter restart at 0 and the sweep erases the word. A `clr_i` pulse during a sweep is ignored, and the sweep ends on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear request pulse |
| in_valid_i | input | 1 | Stream word valid |
| in_ready_o | output | 1 | Stream word ready |
| in_word_i | input | WORD_W | Stream word: bit 31 is the type flag, bits 30:0 the payload |
| busy_o | output | 1 | High while the memory is being cleared |
| rd_addr_i | input | log2(DEPTH) | Read address |
| rd_data_o | output | WORD_W-1 | Read data, one cycle after the address |
| wr_count_o | output | CNT_W | Saturating count of stored data words |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a clear pulse and an accepted word: the bench raises `clr_i` together with a valid data word, then checks that the counter reads 0, that the sweep lasts exactly `DEPTH` cycles despite a second pulse in the middle, and that every location reads zero afterwards. The second pair is a read and a write to the same location: the bench presents the read address in the same cycle as the data word and expects the old zero, then the new value on the following read. A behavioural model with an array and integers predicts `busy_o`, `in_ready_o`, `wr_count_o` and `rd_data_o` on every clock.

// File: rtl/trace_unpack_pkg.sv
package trace_unpack_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP  = 1'b0,
        ST_DECODE = 1'b1
    } unpack_state_e;

endpackage

// File: rtl/trace_unpack_ctrl.sv
module trace_unpack_ctrl
    import trace_unpack_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int PAY_W = WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              in_valid_i,
    input  logic [WORD_W-1:0] in_word_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic              we_o,
    output logic [PTR_W-1:0]  waddr_o,
    output logic [PAY_W-1:0]  wdata_o,
    output logic              cnt_inc_o,
    output logic              cnt_zero_o
);

    unpack_state_e    state_q, state_d;
    logic [PTR_W-1:0] sweep_q;
    logic [PTR_W-1:0] ptr_q;
    logic             accept;
    logic             is_addr;
    logic             sweep_last;

    assign is_addr    = in_word_i[WORD_W-1];
    assign accept     = (state_q == ST_DECODE) && in_valid_i;
    assign sweep_last = (sweep_q == PTR_W'(DEPTH - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP:  state_d = sweep_last ? ST_DECODE : ST_SWEEP;
            ST_DECODE: state_d = clr_i ? ST_SWEEP : ST_DECODE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SWEEP;
        else        state_q <= state_d;
    end

    // sweep index and write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_q <= '0;
            ptr_q   <= '0;
        end else if (state_q == ST_DECODE && clr_i) begin
            sweep_q <= '0;
            ptr_q   <= '0;
        end else if (state_q == ST_SWEEP) begin
            sweep_q <= sweep_q + 1'b1;
        end else if (accept) begin
            if (is_addr) ptr_q <= in_word_i[PTR_W-1:0];
            else         ptr_q <= ptr_q + 1'b1;
        end
    end

    // outputs per state
    always_comb begin
        busy_o     = 1'b0;
        ready_o    = 1'b0;
        we_o       = 1'b0;
        waddr_o    = ptr_q;
        wdata_o    = in_word_i[PAY_W-1:0];
        cnt_inc_o  = 1'b0;
        cnt_zero_o = 1'b0;
        unique case (state_q)
            ST_SWEEP: begin
                busy_o  = 1'b1;
                we_o    = 1'b1;
                waddr_o = sweep_q;
                wdata_o = '0;
            end
            ST_DECODE: begin
                ready_o    = 1'b1;
                we_o       = accept && !is_addr;
                cnt_inc_o  = accept && !is_addr;
                cnt_zero_o = clr_i;
            end
        endcase
    end

    // R1: sweep finishes after the last location
    a_r1_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP && sweep_last) |=> (state_q == ST_DECODE));

    // R10: sweep advances one location per cycle regardless of clr_i
    a_r10_sweep_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP && !sweep_last)
        |=> (state_q == ST_SWEEP && sweep_q == $past(sweep_q) + PTR_W'(1)));

    // R2, R6: clear restarts sweep and pointer
    a_r2_clear_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && clr_i)
        |=> (busy_o && sweep_q == '0 && ptr_q == '0));

    // R4: address word loads the pointer
    a_r4_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_addr && !clr_i)
        |=> (ptr_q == $past(in_word_i[PTR_W-1:0])));

    // R5: data word advances the pointer with wrap
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_addr && !clr_i)
        |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

endmodule

// File: rtl/trace_unpack_mem.sv
module trace_unpack_mem #(
    parameter int DEPTH = 1024,
    parameter int DAT_W = 31,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [PTR_W-1:0] waddr_i,
    input  logic [DAT_W-1:0] wdata_i,
    input  logic [PTR_W-1:0] raddr_i,
    output logic [DAT_W-1:0] rdata_o
);

    logic [DAT_W-1:0] store [DEPTH];

    // read-before-write: nonblocking read sees the old content
    always_ff @(posedge clk) begin
        if (we_i) store[waddr_i] <= wdata_i;
        rdata_o <= store[raddr_i];
    end

endmodule

// File: rtl/trace_unpack_count.sv
module trace_unpack_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n || zero_i)                count_o <= '0;
        else if (inc_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end

    // R9: saturation holds
    a_r9_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX && !zero_i) |=> (count_o == CNT_MAX));

    // R9: one step per stored word below the ceiling
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !zero_i && count_o != CNT_MAX)
        |=> (count_o == $past(count_o) + CNT_W'(1)));

    // R10: clear zeroes the counter even with a word in flight
    a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (count_o == '0));

endmodule

// File: rtl/trace_unpacker.sv
module trace_unpacker #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int PAY_W = WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [WORD_W-1:0] in_word_i,
    output logic              busy_o,
    input  logic [PTR_W-1:0]  rd_addr_i,
    output logic [PAY_W-1:0]  rd_data_o,
    output logic [CNT_W-1:0]  wr_count_o
);

    logic             mem_we;
    logic [PTR_W-1:0] mem_waddr;
    logic [PAY_W-1:0] mem_wdata;
    logic             cnt_inc;
    logic             cnt_zero;

    trace_unpack_ctrl #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .in_valid_i (in_valid_i),
        .in_word_i  (in_word_i),
        .busy_o     (busy_o),
        .ready_o    (in_ready_o),
        .we_o       (mem_we),
        .waddr_o    (mem_waddr),
        .wdata_o    (mem_wdata),
        .cnt_inc_o  (cnt_inc),
        .cnt_zero_o (cnt_zero)
    );

    trace_unpack_mem #(
        .DEPTH (DEPTH),
        .DAT_W (PAY_W)
    ) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

    trace_unpack_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .zero_i  (cnt_zero),
        .inc_i   (cnt_inc),
        .count_o (wr_count_o)
    );

    // R4: an accepted address word never writes memory
    a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && in_word_i[WORD_W-1]) |-> !mem_we);

    // R3: words offered while busy cause no counted store
    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!in_ready_o && !cnt_inc));

endmodule

// File: tb/sim_trace_unpacker.sv
module sim_trace_unpacker;

    localparam int DEPTH = 32;
    localparam int CNT_W = 6;
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr_i = 1'b0;
    logic             in_valid_i = 1'b0;
    logic             in_ready_o;
    logic [31:0]      in_word_i = '0;
    logic             busy_o;
    logic [PTR_W-1:0] rd_addr_i = '0;
    logic [30:0]      rd_data_o;
    logic [CNT_W-1:0] wr_count_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    trace_unpacker #(.DEPTH(DEPTH), .WORD_W(32), .CNT_W(CNT_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .in_word_i  (in_word_i),
        .busy_o     (busy_o),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .wr_count_o (wr_count_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [30:0] m_mem [DEPTH];
    bit          m_known [DEPTH];
    bit          m_busy = 1'b1;
    int          m_idx = 0;
    int          m_ptr = 0;
    int          m_cnt = 0;
    logic [30:0] m_rd = '0;
    bit          m_rd_ok = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b1; m_idx = 0; m_ptr = 0; m_cnt = 0; m_rd_ok = 1'b0;
        end else begin
            m_rd    = m_mem[rd_addr_i];
            m_rd_ok = m_known[rd_addr_i];
            if (m_busy) begin
                m_mem[m_idx] = '0;
                m_known[m_idx] = 1'b1;
                if (m_idx == DEPTH - 1) m_busy = 1'b0;
                m_idx++;
            end else begin
                if (in_valid_i) begin
                    if (in_word_i[31]) begin
                        m_ptr = int'(in_word_i[30:0] % DEPTH);
                    end else begin
                        m_mem[m_ptr] = in_word_i[30:0];
                        m_known[m_ptr] = 1'b1;
                        m_ptr = (m_ptr + 1) % DEPTH;
                        if (m_cnt < CMAX) m_cnt++;
                    end
                end
                if (clr_i) begin
                    m_busy = 1'b1; m_idx = 0; m_ptr = 0; m_cnt = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 busy vs model", 64'(busy_o), 64'(m_busy));
            check("R3 ready vs model", 64'(in_ready_o), 64'(!m_busy));
            check("R9 count vs model", 64'(wr_count_o), 64'(m_cnt));
            if (m_rd_ok) check("R8 read vs model", 64'(rd_data_o), 64'(m_rd));
        end
    end

    task automatic put(input logic [31:0] w);
        in_valid_i = 1'b1;
        in_word_i  = w;
        @(negedge clk);
    endtask

    task automatic peek(input int a, output logic [30:0] v);
        in_valid_i = 1'b0;
        rd_addr_i  = PTR_W'(a);
        @(negedge clk);
        v = rd_data_o;
    endtask

    task automatic expect_loc(input string tag, input int a, input logic [30:0] exp);
        logic [30:0] v;
        peek(a, v);
        check(tag, 64'(v), 64'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_known[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: busy after reset, lasts DEPTH cycles
        check("R1 busy at reset release", 64'(busy_o), 64'd1);
        check("R1 ready low at reset release", 64'(in_ready_o), 64'd0);
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        check("R1 sweep length", 64'(n), 64'(DEPTH));
        for (int i = 0; i < DEPTH; i++) expect_loc("R1 cleared location", i, '0);

        // R6: data before any address word
        put(32'h0000_1111); put(32'h0000_2222); put(32'h0000_3333);
        // R4: address word, only low bits used
        put(32'hFFFF_FFEA);
        put(32'h0000_4444);
        in_valid_i = 1'b0;
        expect_loc("R6 first data at 0", 0, 31'h1111);
        expect_loc("R6 second data at 1", 1, 31'h2222);
        expect_loc("R6 third data at 2", 2, 31'h3333);
        expect_loc("R4 data after jump", 10, 31'h4444);
        for (int i = 3; i < 10; i++) expect_loc("R4 skipped stays zero", i, '0);
        check("R9 count after four data", 64'(wr_count_o), 64'd4);

        // R7: back-to-back address words
        put(32'h8000_0005); put(32'h8000_0014); put(32'h0000_5555);
        in_valid_i = 1'b0;
        expect_loc("R7 last address wins", 20, 31'h5555);
        expect_loc("R7 earlier address unused", 5, '0);

        // R5: wrap from DEPTH-1 to 0
        put(32'h8000_001F); put(32'h0000_6666); put(32'h0000_7777);
        in_valid_i = 1'b0;
        expect_loc("R5 last location", 31, 31'h6666);
        expect_loc("R5 wrapped to zero", 0, 31'h7777);
        expect_loc("R5 neighbour intact", 1, 31'h2222);

        // R8: read and write of one location in the same cycle
        put(32'h8000_000C);
        rd_addr_i = PTR_W'(12);
        put(32'h0000_8888);
        in_valid_i = 1'b0;
        check("R8 same-cycle read old value", 64'(rd_data_o), 64'd0);
        expect_loc("R8 new value next read", 12, 31'h8888);

        // R10: clear together with an accepted data word, second pulse ignored
        in_valid_i = 1'b1;
        in_word_i  = 32'h0000_9999;
        clr_i      = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R10 busy after clear", 64'(busy_o), 64'd1);
        check("R10 count zeroed", 64'(wr_count_o), 64'd0);
        n = 0;
        while (busy_o) begin
            clr_i = (n == 5);
            n++;
            @(negedge clk);
        end
        clr_i = 1'b0;
        in_valid_i = 1'b0;
        check("R10 sweep not restarted", 64'(n), 64'(DEPTH));
        check("R3 words during sweep not taken", 64'(wr_count_o), 64'd0);
        for (int i = 0; i < DEPTH; i++) expect_loc("R2 cleared after pulse", i, '0);

        // R9: saturation with an unbroken run of data words
        for (int k = 0; k < 70; k++) put(32'h0000_0100 + 32'(k));
        in_valid_i = 1'b0;
        check("R9 count saturates", 64'(wr_count_o), 64'(CMAX));
        expect_loc("R3 no-gap last word", 5, 31'h0100 + 31'd69);
        expect_loc("R3 no-gap earlier word", 6, 31'h0100 + 31'd38);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule